// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block manages a ring of transmit buffer descriptors kept in a small on-chip descriptor table that the host can also read and write. Each descriptor occupies two 32-bit words: the even word (index 2i) carries status and control, and the odd word (index 2i+1) holds the buffer address. The host fills in a descriptor and sets its ready flag. The engine walks the ring one entry at a time. When it finds a ready entry, it hands the frame length, the buffer address and the per-frame pad and CRC options to a transmit engine over a start/done handshake.

When the transmit engine reports completion together with its nine status bits, the block writes those bits back into the descriptor and clears the ready flag. It raises a one-cycle frame or error event if the descriptor asked for one, then moves on. The host splits the table into a transmit part and a receive part by programming a transmit descriptor count. Receive descriptors begin at the index equal to that count, and the block reports this index to the receive side. The ring closes either at a descriptor whose wrap flag is set or at the last transmit descriptor.

Host writes to the table always win over the engine's writeback. If the two collide, the engine reads the status word again and merges its result into the host's latest contents.

Top module: `txbd_ring_engine`

## Requirements
- R1: The host reads and writes any table word through host_addr (word 2i = status of descriptor i, word 2i+1 = buffer address); read data appears on host_rdata one clock after the read request, and host_rdata is 0 after reset.
- R2: The effective transmit count is min(tx_count, NUM_DESC) and is driven on rx_base; with an effective count of 0 the engine starts no transmission.
- R3: The engine launches only descriptors whose ready bit (bit 15) is set, and it keeps polling a descriptor whose ready bit is clear without advancing past it.
- R4: A launch is a one-cycle xm_start pulse with xm_len = status bits 31:16, xm_addr = the odd word, xm_pad = bit 12 and xm_crc = bit 11; these outputs stay stable until xm_done.
- R5: On xm_done the status word becomes: bits 31:16 and 14:9 as currently stored, bit 15 cleared, bits 8:0 = xm_stat (bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun).
- R6: After a writeback the next descriptor is 0 if the wrap bit (bit 13) was set or the current index is the last transmit descriptor; otherwise it is the current index plus 1.
- R7: After a writeback with interrupt enable (bit 14) set, ev_error pulses for one cycle if any of xm_stat bits 0, 1, 2, 3 or 8 was set, and ev_frame pulses otherwise; the retry count alone is not an error; with bit 14 clear neither pulses.
- R8: While tx_en is low the engine starts no transmission; when tx_en rises, a pending ready descriptor is launched.
- R9: A host write in the same cycle as the engine's writeback wins, the engine's write is dropped, and the engine re-reads and completes the writeback only after host writes stop, leaving the host's data intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host table access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 8 | Host table word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the request |
| tx_en | input | 1 | Transmit fetch enable |
| tx_count | input | 8 | Requested number of transmit descriptors |
| rx_base | output | 8 | First receive descriptor index (effective transmit count) |
| xm_start | output | 1 | One-cycle frame launch pulse |
| xm_len | output | 16 | Frame length in bytes |
| xm_addr | output | 32 | Frame buffer address |
| xm_pad | output | 1 | Pad short frame |
| xm_crc | output | 1 | Append CRC |
| xm_done | input | 1 | Transmit engine completion pulse |
| xm_stat | input | 9 | Completion status bits |
| ev_frame | output | 1 | Successful frame event pulse |
| ev_error | output | 1 | Failed frame event pulse |

## Verification
On every cycle the assertions check several properties. Each launch is a single pulse issued only while transmit is enabled. The engine never writes a status word with the ready bit still set. A host write that collides with the engine's write leaves the host's data in the table. The two event pulses never fire together, and the descriptor index only steps by one or returns to zero. Other behaviour needs the bench's scenarios to show it: the exact writeback contents, the choice between frame and error event, ring ordering at the count limit and at the wrap bit, stalling on a descriptor that is not ready, and recovery after a long stretch of host writes.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int ST_READY = 15;
  localparam int ST_IRQ   = 14;
  localparam int ST_WRAP  = 13;
  localparam int ST_PAD   = 12;
  localparam int ST_CRC   = 11;
  localparam int STAT_W   = 9;
  localparam logic [STAT_W-1:0] ERR_MASK = 9'h10F;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_LAUNCH, S_WAIT, S_WBRD, S_WBWR
  } ring_state_e;
endpackage

// File: rtl/txbd_count_clamp.sv
module txbd_count_clamp #(
  parameter int NUM_DESC = 128,
  parameter int CW       = $clog2(NUM_DESC + 1)
) (
  input  logic [CW-1:0] req_count,
  output logic [CW-1:0] eff_count,
  output logic          none
);
  always_comb begin
    if (req_count > CW'(NUM_DESC)) eff_count = CW'(NUM_DESC);
    else                           eff_count = req_count;
    none = (eff_count == '0);
  end
endmodule

// File: rtl/txbd_table.sv
module txbd_table #(
  parameter int NUM_DESC = 128,
  parameter int AW       = $clog2(NUM_DESC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [31:0]   eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [31:0]   eng_wdata
);
  localparam int WORDS = 2 * NUM_DESC;

  logic [31:0] mem [WORDS];
  logic        host_wr;
  logic        host_rd;
  logic        wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;

  always_comb begin
    host_wr = host_en && host_we;
    host_rd = host_en && !host_we;
    wr_en   = host_wr || eng_we;
    if (host_wr) begin
      wr_addr = host_addr;
      wr_data = host_wdata;
    end else begin
      wr_addr = eng_waddr;
      wr_data = eng_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    eng_rdata <= mem[eng_raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= mem[host_addr];
  end

  // R9: the host's word survives a same-cycle engine write
  a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && eng_we) |=> (mem[$past(host_addr)] == $past(host_wdata)));

  // R5: the engine never stores a status word that is still ready
  a_r5_wb_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !eng_wdata[15]);
endmodule

// File: rtl/txbd_ring_fsm.sv
module txbd_ring_fsm
  import txbd_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int IW       = $clog2(NUM_DESC),
  parameter int AW       = IW + 1,
  parameter int CW       = $clog2(NUM_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [CW-1:0]     eff_count,
  input  logic              count_none,
  input  logic              host_wr,
  output logic [AW-1:0]     eng_raddr,
  input  logic [31:0]       eng_rdata,
  output logic              eng_we,
  output logic [AW-1:0]     eng_waddr,
  output logic [31:0]       eng_wdata,
  output logic              xm_start,
  output logic [15:0]       xm_len,
  output logic [31:0]       xm_addr,
  output logic              xm_pad,
  output logic              xm_crc,
  input  logic              xm_done,
  input  logic [STAT_W-1:0] xm_stat,
  output logic              ev_frame,
  output logic              ev_error
);
  ring_state_e state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              start_d;
  logic [15:0]       len_d;
  logic [31:0]       addr_d;
  logic              pad_d, crc_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              evf_d, eve_d;
  logic              run_ok;
  logic [CW-1:0]     idx_plus;
  logic              is_last;
  logic              is_err;

  always_comb begin
    run_ok    = tx_en && !count_none;
    idx_plus  = CW'(idx_q) + CW'(1);
    is_last   = (idx_plus >= eff_count);
    is_err    = |(stat_q & ERR_MASK);
    eng_waddr = {idx_q, 1'b0};
    eng_wdata = {eng_rdata[31:ST_READY+1], 1'b0, eng_rdata[ST_READY-1:STAT_W], stat_q};
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    start_d   = 1'b0;
    len_d     = xm_len;
    addr_d    = xm_addr;
    pad_d     = xm_pad;
    crc_d     = xm_crc;
    stat_d    = stat_q;
    evf_d     = 1'b0;
    eve_d     = 1'b0;
    eng_raddr = {idx_q, 1'b0};
    eng_we    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (run_ok) state_d = S_FETCH;
      end
      S_FETCH: begin
        state_d = run_ok ? S_CHECK : S_IDLE;
      end
      S_CHECK: begin
        eng_raddr = {idx_q, 1'b1};
        if (run_ok && eng_rdata[ST_READY]) begin
          len_d   = eng_rdata[31:16];
          pad_d   = eng_rdata[ST_PAD];
          crc_d   = eng_rdata[ST_CRC];
          state_d = S_LAUNCH;
        end else begin
          state_d = run_ok ? S_FETCH : S_IDLE;
        end
      end
      S_LAUNCH: begin
        if (tx_en) begin
          addr_d  = eng_rdata;
          start_d = 1'b1;
          state_d = S_WAIT;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_WAIT: begin
        if (xm_done) begin
          stat_d  = xm_stat;
          state_d = S_WBRD;
        end
      end
      S_WBRD: begin
        if (!host_wr) state_d = S_WBWR;
      end
      S_WBWR: begin
        eng_we = 1'b1;
        if (host_wr) begin
          state_d = S_WBRD;
        end else begin
          evf_d   = eng_rdata[ST_IRQ] && !is_err;
          eve_d   = eng_rdata[ST_IRQ] && is_err;
          idx_d   = (eng_rdata[ST_WRAP] || is_last) ? '0 : idx_q + IW'(1);
          state_d = S_FETCH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      xm_start <= 1'b0;
      xm_len   <= '0;
      xm_addr  <= '0;
      xm_pad   <= 1'b0;
      xm_crc   <= 1'b0;
      stat_q   <= '0;
      ev_frame <= 1'b0;
      ev_error <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      xm_start <= start_d;
      xm_len   <= len_d;
      xm_addr  <= addr_d;
      xm_pad   <= pad_d;
      xm_crc   <= crc_d;
      stat_q   <= stat_d;
      ev_frame <= evf_d;
      ev_error <= eve_d;
    end
  end

  // R4: a launch lasts exactly one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xm_start |=> !xm_start);

  // R8: no launch unless transmit was enabled
  a_r8_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    xm_start |-> $past(tx_en));

  // R7: at most one event kind per cycle
  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_frame, ev_error}) <= 1);

  // R6: the ring index steps by one or returns to zero
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> (idx_q == '0 || idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txbd_pkg::*;
#(
  parameter int NUM_DESC = 128,
  parameter int IW       = $clog2(NUM_DESC),
  parameter int AW       = IW + 1,
  parameter int CW       = $clog2(NUM_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              tx_en,
  input  logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_base,
  output logic              xm_start,
  output logic [15:0]       xm_len,
  output logic [31:0]       xm_addr,
  output logic              xm_pad,
  output logic              xm_crc,
  input  logic              xm_done,
  input  logic [STAT_W-1:0] xm_stat,
  output logic              ev_frame,
  output logic              ev_error
);
  logic          count_none;
  logic          host_wr;
  logic [AW-1:0] eng_raddr;
  logic [31:0]   eng_rdata;
  logic          eng_we;
  logic [AW-1:0] eng_waddr;
  logic [31:0]   eng_wdata;

  assign host_wr = host_en && host_we;

  txbd_count_clamp #(.NUM_DESC(NUM_DESC), .CW(CW)) u_clamp (
    .req_count (tx_count),
    .eff_count (rx_base),
    .none      (count_none)
  );

  txbd_table #(.NUM_DESC(NUM_DESC), .AW(AW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_en    (host_en),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );

  txbd_ring_fsm #(.NUM_DESC(NUM_DESC), .IW(IW), .AW(AW), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .eff_count  (rx_base),
    .count_none (count_none),
    .host_wr    (host_wr),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata),
    .xm_start   (xm_start),
    .xm_len     (xm_len),
    .xm_addr    (xm_addr),
    .xm_pad     (xm_pad),
    .xm_crc     (xm_crc),
    .xm_done    (xm_done),
    .xm_stat    (xm_stat),
    .ev_frame   (ev_frame),
    .ev_error   (ev_error)
  );
endmodule

// File: tb/sim_txbd_ring_engine.sv
module sim_txbd_ring_engine;
  logic        clk;
  logic        rst_n;
  logic        host_en, host_we;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        tx_en;
  logic [7:0]  tx_count, rx_base;
  logic        xm_start, xm_pad, xm_crc, xm_done;
  logic [15:0] xm_len;
  logic [31:0] xm_addr;
  logic [8:0]  xm_stat;
  logic        ev_frame, ev_error;

  int n_chk = 0;
  int n_fail = 0;
  int n_evf = 0;
  int n_eve = 0;
  int cycles = 0;
  int idx = 0;

  txbd_ring_engine u0 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_en(tx_en), .tx_count(tx_count), .rx_base(rx_base),
    .xm_start(xm_start), .xm_len(xm_len), .xm_addr(xm_addr),
    .xm_pad(xm_pad), .xm_crc(xm_crc), .xm_done(xm_done), .xm_stat(xm_stat),
    .ev_frame(ev_frame), .ev_error(ev_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ev_frame) n_evf++;
    if (ev_error) n_eve++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  // fields: [60:45] len, [44] irq, [43] wrap, [42] pad, [41] crc, [40:9] addr, [8:0] stat
  localparam logic [60:0] VEC [6] = '{
    {16'd64,   1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_1000, 9'h000},
    {16'd42,   1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_2000, 9'h034},
    {16'd1500, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_3000, 9'h000},
    {16'd100,  1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_4000, 9'h100},
    {16'd60,   1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_5000, 9'h020},
    {16'd200,  1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_6000, 9'h001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_en = 1'b0;
    d = host_rdata;
  endtask

  // waits at falling edges for a launch pulse; returns 1 if seen
  task automatic wait_start(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (xm_start) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic finish_frame(input logic [8:0] st);
    @(negedge clk);
    xm_done = 1'b1; xm_stat = st;
    @(negedge clk);
    xm_done = 1'b0; xm_stat = '0;
  endtask

  function automatic logic [31:0] stat_word(input logic [15:0] len, input logic irq,
      input logic wrap, input logic pad, input logic crc, input logic rdy);
    return {len, rdy, irq, wrap, pad, crc, 11'd0};
  endfunction

  task automatic next_idx(input logic wrap);
    if (wrap || idx + 1 >= 4) idx = 0;
    else idx = idx + 1;
  endtask

  initial begin
    logic [31:0] rd;
    bit seen;
    int ef, ee;
    rst_n = 1'b0; host_en = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    tx_en = 1'b0; tx_count = 8'd4; xm_done = 1'b0; xm_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset host_rdata", host_rdata, 32'h0);
    check("R4 reset xm_start", {31'd0, xm_start}, 32'h0);
    check("R7 reset events", {30'd0, ev_frame, ev_error}, 32'h0);
    check("R2 rx_base count 4", {24'd0, rx_base}, 32'd4);

    for (int d = 0; d < 8; d++) hwrite(8'(2 * d), 32'h0);
    hwrite(8'd9, 32'hCAFE_0009);
    hread(8'd9, rd);
    check("R1 host read back", rd, 32'hCAFE_0009);

    tx_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      logic [15:0] len; logic irq, wrap, pad, crc; logic [31:0] ad; logic [8:0] st;
      {len, irq, wrap, pad, crc, ad, st} = VEC[v];
      ef = n_evf; ee = n_eve;
      hwrite(8'(2 * idx + 1), ad);
      hwrite(8'(2 * idx), stat_word(len, irq, wrap, pad, crc, 1'b1));
      wait_start(200, seen);
      check("R3 ready descriptor launched", {31'd0, seen}, 32'd1);
      check("R4 xm_len", {16'd0, xm_len}, {16'd0, len});
      check("R6 xm_addr selects ring order", xm_addr, ad);
      check("R4 pad/crc", {30'd0, xm_pad, xm_crc}, {30'd0, pad, crc});
      repeat (3) @(negedge clk);
      check("R4 fields held until done", xm_addr, ad);
      finish_frame(st);
      repeat (8) @(negedge clk);
      hread(8'(2 * idx), rd);
      check("R5 writeback status", rd, stat_word(len, irq, wrap, pad, crc, 1'b0) | {23'd0, st});
      check("R7 frame event", n_evf - ef, (irq && (st & 9'h10F) == 0) ? 1 : 0);
      check("R7 error event", n_eve - ee, (irq && (st & 9'h10F) != 0) ? 1 : 0);
      next_idx(wrap);
    end

    // R3: descriptor 1 not ready, descriptor 2 ready: engine must stall on 1
    check("R6 index after table", idx, 1);
    hwrite(8'd3, 32'h0000_A100);
    hwrite(8'd2, stat_word(16'd80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    hwrite(8'd5, 32'h0000_A200);
    hwrite(8'd4, stat_word(16'd90, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_start(40, seen);
    check("R3 no advance past not-ready", {31'd0, seen}, 32'd0);
    hwrite(8'd2, stat_word(16'd80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_start(200, seen);
    check("R3 stalled descriptor launched", xm_addr, 32'h0000_A100);
    finish_frame(9'h000);
    wait_start(200, seen);
    check("R6 next descriptor launched", xm_addr, 32'h0000_A200);
    finish_frame(9'h000);
    repeat (6) @(negedge clk);

    // R8: transmit disabled
    tx_en = 1'b0;
    hwrite(8'd7, 32'h0000_B300);
    hwrite(8'd6, stat_word(16'd70, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_start(40, seen);
    check("R8 no launch while disabled", {31'd0, seen}, 32'd0);
    tx_en = 1'b1;
    wait_start(200, seen);
    check("R8 launch after enable", xm_addr, 32'h0000_B300);
    finish_frame(9'h000);
    repeat (6) @(negedge clk);

    // R9: host writes cover the writeback window
    ef = n_evf;
    hwrite(8'd1, 32'h0000_C000);
    hwrite(8'd0, stat_word(16'd128, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_start(200, seen);
    check("R9 launch before conflict", xm_addr, 32'h0000_C000);
    @(negedge clk);
    xm_done = 1'b1; xm_stat = 9'h040;
    @(negedge clk);
    xm_done = 1'b0; xm_stat = '0;
    host_en = 1'b1; host_we = 1'b1; host_addr = 8'd7; host_wdata = 32'h7777_0007;
    repeat (20) @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
    check("R9 writeback deferred during host writes", n_evf - ef, 0);
    repeat (8) @(negedge clk);
    check("R9 writeback after host writes", n_evf - ef, 1);
    hread(8'd0, rd);
    check("R9 merged status", rd, stat_word(16'd128, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0) | 32'h40);
    hread(8'd7, rd);
    check("R9 host data intact", rd, 32'h7777_0007);

    // R2: clamp and empty transmit section
    tx_count = 8'd200;
    @(negedge clk);
    check("R2 clamp to table size", {24'd0, rx_base}, 32'd128);
    tx_count = 8'd0;
    @(negedge clk);
    check("R2 zero count", {24'd0, rx_base}, 32'd0);
    hwrite(8'd3, 32'h0000_D000);
    hwrite(8'd2, stat_word(16'd50, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    wait_start(40, seen);
    check("R2 no launch with zero count", {31'd0, seen}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule